// File: doc/BRIEF.md
# Soft-Start Ramp Controller

This block generates an 8-bit drive code for a digital-to-analog converter that feeds a power stage. Its job is an asymmetric switching profile: one direction of the transition is a slow staircase that the code climbs or descends one count at a time, and the other direction is a jump in a single clock. The staircase rate comes from a programmable prescaler on the system clock. The full span is 255 steps, so the ramp lasts 255 × (divisor + 1) clock cycles.

A build-time parameter selects the direction. In the default soft-on mode, raising `enable` starts an upward ramp and dropping it zeroes the code at once. In the soft-off mode the roles swap. Raising `enable` loads full scale at once, and dropping it starts a downward ramp to zero. A `done` output shows that the code has settled at the end value for the current `enable` level.

Top module: `soft_ramp_ctrl`

## Requirements
- R1: While `rstN` is low the code is 0 and `done` is 1.
- R2: In soft-on mode (RAMP_DOWN = 0), a clock edge that samples `enable` low sets the code to 0 at that edge, from any point of the ramp.
- R3: In soft-on mode, while `enable` stays high the code rises by exactly one every `divisor` + 1 clock edges. The first step lands on the (`divisor` + 1)-th edge that samples `enable` high, so the code after the n-th such edge is n / (`divisor` + 1), rounded down.
- R4: The code stops at 255 and never wraps past it. In soft-off mode it stops at 0 and never wraps below it.
- R5: In soft-off mode (RAMP_DOWN = 1), a clock edge that samples `enable` high sets the code to 255 at that edge.
- R6: In soft-off mode, while `enable` stays low the code falls by exactly one every `divisor` + 1 clock edges. It counts from the value it held when `enable` fell, so after the n-th low edge it is that value minus n / (`divisor` + 1), rounded down, and never less than 0.
- R7: `done` is 1 exactly when the code equals its end value for the `enable` level sampled at the last edge. The end value is 255 when that level is high and 0 when it is low.
- R8: The prescaler restarts on every change of `enable`. Timing of the first step therefore does not depend on how far the prescaler had counted in the previous phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Output-on request, sampled on each rising clock edge |
| divisor | input | DIV_W (16) | Prescaler setting; one step every divisor + 1 cycles |
| code | output | CODE_W (8) | Drive code for the converter |
| done | output | 1 | Code is at the end value for the current enable level |

## Verification
The important collision is a change of `enable` on the same edge as a prescaler tick. The jump must win over the step, and the next ramp must start its count from zero. The bench provokes this directly by holding `enable` for an exact multiple of `divisor` + 1 cycles before flipping it. Random phase lengths and divisors add many more of these collisions. Saturation against a tick is exercised by holds well beyond the ramp length. Both modes share one stimulus, and each is judged every cycle against a closed-form expected code computed from the edge count since the last `enable` change.

// File: rtl/soft_ramp_pkg.sv
package soft_ramp_pkg;

  // Strobes passed from the control module to the code register.
  typedef struct packed {
    logic clear;     // force code to zero
    logic loadFull;  // force code to full scale
    logic stepUp;    // add one
    logic stepDown;  // subtract one
  } rampStrobe_t;

endpackage

// File: rtl/ramp_ctrl.sv
module ramp_ctrl
  import soft_ramp_pkg::*;
#(
  parameter int DIV_W     = 16,
  parameter bit RAMP_DOWN = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [DIV_W-1:0] divisor,
  input  logic             atMax,
  input  logic             atMin,
  output rampStrobe_t      stb,
  output logic             enableQ
);

  logic [DIV_W-1:0] preCnt;
  logic             ramping;
  logic             tick;
  logic             jump;

  // The ramping direction is the one that follows the enable level chosen by the mode.
  generate
    if (RAMP_DOWN) begin : g_softOff
      assign ramping = !enable;
      assign jump    = enable;
    end else begin : g_softOn
      assign ramping = enable;
      assign jump    = !enable;
    end
  endgenerate

  // Use >= so a divisor lowered mid-ramp cannot leave the counter stranded above it.
  assign tick = ramping && (preCnt >= divisor);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      enableQ <= 1'b0;
    end else begin
      enableQ <= enable;
      if (!ramping || tick) preCnt <= '0;
      else                  preCnt <= preCnt + 1'b1;
    end
  end

  always_comb begin
    stb          = '0;
    stb.clear    = !RAMP_DOWN && jump;
    stb.loadFull = RAMP_DOWN && jump;
    stb.stepUp   = !RAMP_DOWN && tick && !atMax;
    stb.stepDown = RAMP_DOWN && tick && !atMin;
  end

  // The counter is held at zero whenever the ramp is not running.
  AST_PRESCALE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !ramping |=> (preCnt == '0)); // R8

  // At most one strobe is active in any cycle.
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.clear, stb.loadFull, stb.stepUp, stb.stepDown})); // R3

endmodule

// File: rtl/ramp_datapath.sv
module ramp_datapath
  import soft_ramp_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  rampStrobe_t       stb,
  input  logic              enableQ,
  output logic [CODE_W-1:0] code,
  output logic              atMax,
  output logic              atMin,
  output logic              done
);

  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              code <= '0;
    else if (stb.clear)     code <= '0;
    else if (stb.loadFull)  code <= CODE_MAX;
    else if (stb.stepUp)    code <= code + 1'b1;
    else if (stb.stepDown)  code <= code - 1'b1;
  end

  assign atMax = (code == CODE_MAX);
  assign atMin = (code == '0);
  assign done  = enableQ ? atMax : atMin;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (atMax && !stb.clear && !stb.stepDown) |=> (code == CODE_MAX)); // R4

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (atMin && !stb.loadFull && !stb.stepUp) |=> (code == '0)); // R4

  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.clear && !stb.loadFull) |=>
      ((code == $past(code)) || (code == $past(code) + 1'b1) || (code == $past(code) - 1'b1))); // R3

endmodule

// File: rtl/soft_ramp_ctrl.sv
module soft_ramp_ctrl
  import soft_ramp_pkg::*;
#(
  parameter int CODE_W    = 8,
  parameter int DIV_W     = 16,
  parameter bit RAMP_DOWN = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [DIV_W-1:0]  divisor,
  output logic [CODE_W-1:0] code,
  output logic              done
);

  localparam logic [CODE_W-1:0] FULL_SCALE = {CODE_W{1'b1}};

  rampStrobe_t stb;
  logic        enableQ;
  logic        atMax;
  logic        atMin;

  ramp_ctrl #(
    .DIV_W    (DIV_W),
    .RAMP_DOWN(RAMP_DOWN)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .enable (enable),
    .divisor(divisor),
    .atMax  (atMax),
    .atMin  (atMin),
    .stb    (stb),
    .enableQ(enableQ)
  );

  ramp_datapath #(
    .CODE_W(CODE_W)
  ) u_path (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .enableQ(enableQ),
    .code   (code),
    .atMax  (atMax),
    .atMin  (atMin),
    .done   (done)
  );

  generate
    if (RAMP_DOWN) begin : g_chkOff
      AST_ON_AT_ONCE: assert property (@(posedge clk) disable iff (!rstN)
        enable |=> (code == FULL_SCALE)); // R5
    end else begin : g_chkOn
      AST_OFF_AT_ONCE: assert property (@(posedge clk) disable iff (!rstN)
        !enable |=> (code == '0)); // R2
    end
  endgenerate

  AST_DONE_END: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ((code == FULL_SCALE) || (code == '0))); // R7

endmodule

// File: tb/soft_ramp_ctrl_tb.sv
`timescale 1ns/1ps
module soft_ramp_ctrl_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic [15:0] divisor = 16'd0;
  logic [7:0]  codeUp, codeDn;
  logic        doneUp, doneDn;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  // Reference state: edges since the last enable change, and the soft-off start value.
  int  edgeCnt  = 0;
  bit  prevEn   = 1'b0;
  int  dnStart  = 0;
  int  divNow   = 0;
  int  expUp    = 0;
  int  expDn    = 0;

  always #5 clk = ~clk;

  soft_ramp_ctrl #(.CODE_W(8), .DIV_W(16), .RAMP_DOWN(1'b0)) u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .divisor(divisor),
    .code(codeUp), .done(doneUp));

  soft_ramp_ctrl #(.CODE_W(8), .DIV_W(16), .RAMP_DOWN(1'b1)) u_dutDn (
    .clk(clk), .rstN(rstN), .enable(enable), .divisor(divisor),
    .code(codeDn), .done(doneDn));

  function automatic int upModel(bit en, int n, int d);
    int v;
    if (!en) return 0;
    v = n / (d + 1);
    return (v > 255) ? 255 : v;
  endfunction

  function automatic int dnModel(bit en, int n, int d, int start);
    int v;
    if (en) return 255;
    v = start - n / (d + 1);
    return (v < 0) ? 0 : v;
  endfunction

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, actual, expected, $time);
    end
  endtask

  // One clock: apply inputs, advance the reference at the edge, compare at the falling edge.
  task automatic cycle(bit en, int d);
    enable  = en;
    divisor = d[15:0];
    @(posedge clk);
    if (en != prevEn) begin
      if (!en) dnStart = expDn;
      edgeCnt = 1;
      divNow  = d;
    end else begin
      edgeCnt++;
    end
    prevEn = en;
    expUp = upModel(en, edgeCnt, divNow);
    expDn = dnModel(en, edgeCnt, divNow, dnStart);
    @(negedge clk);
    if (en) check("R3/R4 up-mode code", codeUp, expUp);
    else    check("R2 up-mode code", codeUp, expUp);
    if (en) check("R5 down-mode code", codeDn, expDn);
    else    check("R6/R4 down-mode code", codeDn, expDn);
    check("R7 done up-mode", doneUp, (en ? (expUp == 255) : (expUp == 0)));
    check("R7 done down-mode", doneDn, (en ? (expDn == 255) : (expDn == 0)));
  endtask

  task automatic phase(bit en, int d, int len);
    for (int i = 0; i < len; i++) cycle(en, d);
  endtask

  initial begin
    #3_000_000;
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int d;
    int len;
    void'($urandom(32'd1987));
    repeat (3) @(negedge clk);
    // R1: reset state of both variants.
    check("R1 reset code up", codeUp, 0);
    check("R1 reset done up", doneUp, 1);
    check("R1 reset code down", codeDn, 0);
    check("R1 reset done down", doneDn, 1);
    rstN = 1'b1;

    // Directed: fastest ramp to saturation and a long hold (R3, R4, R6).
    phase(1'b0, 0, 3);
    phase(1'b1, 0, 300);
    phase(1'b0, 0, 300);
    // Directed: divisor 3, enable drops exactly on a tick edge (R2, R8).
    phase(1'b1, 3, 40);
    phase(1'b0, 3, 12);
    // Directed: single-cycle pulses (R2, R5, R8).
    phase(1'b1, 1, 1);
    phase(1'b0, 1, 1);
    phase(1'b1, 1, 5);
    phase(1'b0, 1, 9);
    // Directed: large divisor, short span (R3, R6).
    phase(1'b1, 200, 1500);
    phase(1'b0, 200, 1500);

    // Random phases, sometimes sized to end on a tick edge.
    for (int p = 0; p < 60; p++) begin
      d = ($urandom % 4 == 0) ? int'($urandom % 8) : int'($urandom % 3);
      len = 1 + int'($urandom % 1100);
      if ($urandom % 3 == 0) len = (d + 1) * (1 + int'($urandom % 40));
      phase(p[0] ? 1'b0 : 1'b1, d, len);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule